// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-side register interface of an audio codec. The host sees four byte-wide direct ports, picked by a 2-bit address. The first is an index port. The second is a data window onto a bank of up to 32 indirect 8-bit control registers. The third is a status port carrying the interrupt flag. The fourth is a programmed-I/O data port, which reads as zero. The host first writes a register number to the index port and then reads or writes the window.

The block applies the access rules of the indirect bank. These cover reset values, locked and reserved entries, and a mode bit that widens the reachable index range from 16 to 32. The sample-format register can only be changed while a mode-change enable is set. Both the status port and the alternate status register clear the interrupt. A short counter emulates a calibration-busy bit after each mode-change entry.

A playback engine outside this block raises a one-cycle `pb_done_i` pulse when its count expires. It receives the decoded format, enable, interrupt enable and 16-bit count from the register bank.

Top module: `codec_regs`

## Requirements
- R1: After reset the index port reads 0x40 and the status and PIO ports read 0x00. The indirect registers read 0x88 at 2–5, 18 and 19; 0x80 at 6 and 7; 0x08 at 9; 0x8A at 12; 0xA0 at 25 and 26; and 0x00 everywhere else.
- R2: Bit 7 of the index port is stored as 0 on write and always reads as 0.
- R3: While bit 6 of register 12 is clear, only index bits [3:0] select the indirect register. While it is set, bits [4:0] select it.
- R4: A write to register 12 changes only its bit 6. `mode2_o` follows that bit.
- R5: Writes to registers 11, 22, 27 and 29 are ignored.
- R6: A write to register 9 always stores bit 5 as 0.
- R7: A write to register 8 is stored in full while index bit 6 is set. If index bit 6 is clear and bit 4 of register 24 is set, only bits [7:4] are updated and bits [3:0] are kept. If both are clear, the write is dropped.
- R8: A write to the index port that takes bit 6 from 0 to 1 while register 9 bits [4:3] are non-zero loads the calibration counter with CAL_LOAD (default 1). A write that does not meet both conditions leaves the counter unchanged. Each read (`rd_i`) of register 11 while the counter is non-zero returns bit 5 set and decrements the counter.
- R9: Any write to the status port clears the INT flag (status bit 0 and `irq_o`) and clears bits [6:4] of register 24.
- R10: A write to register 24 that takes its bit 4 from 1 to 0 clears INT.
- R11: A `pb_done_i` pulse sets INT and bit 4 of register 24. If it comes in the same cycle as a clear, the set takes priority.
- R12: The outputs are driven from the register bank as follows: `play_fmt_o` = register 8, `play_en_o` = register 9 bit 0, `irq_en_o` = register 10 bit 1, and `play_count_o` = {register 14, register 15}.
- R13: Writes to the PIO port are ignored, and the PIO port always reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Direct port select: 0 index, 1 data, 2 status, 3 PIO |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, used for read side effects |
| wdata_i | input | 8 | Write data |
| pb_done_i | input | 1 | Playback count expired pulse |
| rdata_o | output | 8 | Combinational read data of the selected port |
| irq_o | output | 1 | Interrupt line (status INT) |
| play_fmt_o | output | 8 | Sample format and rate (register 8) |
| play_en_o | output | 1 | Playback enable (register 9 bit 0) |
| irq_en_o | output | 1 | Interrupt enable (register 10 bit 1) |
| play_count_o | output | 16 | Playback base count {reg 14, reg 15} |
| mode2_o | output | 1 | Extended index mode (register 12 bit 6) |

## Verification
The bench reads back every indirect register in both index modes after reset and after two write sweeps. A wrong index width would return a folded or out-of-range register, and a missing lock would expose bytes written to reserved slots. The format register is written under each of its three gate conditions. A design that ignored the alternate-status bit would drop or fully accept the nibble-merge write. The calibration bit is checked after a true rising edge, after a rise with calibration disabled, and on a second read. A counter that fails to load or decrement would show bit 5 on the wrong reads. The interrupt is set by `pb_done_i` and then cleared by both paths. A simultaneous set and clear is also driven, where a design with the wrong priority would lose the event.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } port_e;

  localparam int IX_FMT      = 8;
  localparam int IX_CFG      = 9;
  localparam int IX_PIN      = 10;
  localparam int IX_INIT     = 11;
  localparam int IX_MODE     = 12;
  localparam int IX_CNT_HI   = 14;
  localparam int IX_CNT_LO   = 15;
  localparam int IX_RSV_A    = 22;
  localparam int IX_ALT_STAT = 24;
  localparam int IX_RSV_B    = 27;
  localparam int IX_RSV_C    = 29;

  localparam int MCE_BIT   = 6;
  localparam int MODE2_BIT = 6;
  localparam int PB_IRQ_BIT = 4;

  function automatic logic [7:0] ireg_reset(input int idx);
    case (idx)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic ireg_locked(input int idx);
    return (idx == IX_INIT) || (idx == IX_RSV_A) || (idx == IX_RSV_B) || (idx == IX_RSV_C);
  endfunction
endpackage

// File: rtl/codec_index_port.sv
module codec_index_port #(
  parameter int DW = 8,
  parameter int IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          mode2_i,
  output logic [DW-1:0] idx_o,
  output logic [IW-1:0] iaddr_o,
  output logic          mce_o,
  output logic          mce_rise_o
);
  import codec_reg_pkg::*;

  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= DW'(8'h40);
    else if (wr_i) idx_q <= {1'b0, wdata_i[DW-2:0]};
  end

  assign idx_o      = idx_q;
  assign mce_o      = idx_q[MCE_BIT];
  assign mce_rise_o = wr_i && !idx_q[MCE_BIT] && wdata_i[MCE_BIT];
  // legacy mode folds the top index bit away
  assign iaddr_o    = mode2_i ? idx_q[IW-1:0] : {1'b0, idx_q[IW-2:0]};

  p_legacy_win_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode2_i |-> !iaddr_o[IW-1]);
endmodule

// File: rtl/codec_cal_emu.sv
module codec_cal_emu #(
  parameter int CAL_LOAD = 1,
  parameter int CW = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic rd_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CW'(CAL_LOAD);
    else if (rd_i && busy_o) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;

  p_cal_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == CW'(CAL_LOAD));
  p_cal_dec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && busy_o && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_cal_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !rd_i) |=> $stable(cnt_q));
endmodule

// File: rtl/codec_ireg_file.sv
module codec_ireg_file #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  parameter int IW   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [IW-1:0]            iaddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     mce_i,
  input  logic                     stat_clr_i,
  input  logic                     pb_done_i,
  output logic [NREG-1:0][DW-1:0]  regs_o,
  output logic                     int_o
);
  import codec_reg_pkg::*;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic [DW-1:0]           nv;
  logic                    gate_ok;
  logic                    int_q;

  always_comb begin
    nv      = wdata_i;
    gate_ok = 1'b1;
    case (int'(iaddr_i))
      IX_FMT: begin
        if (!mce_i) begin
          if (regs_q[IX_ALT_STAT][PB_IRQ_BIT])
            nv = {wdata_i[DW-1:4], regs_q[IX_FMT][3:0]};
          else
            gate_ok = 1'b0;
        end
      end
      IX_CFG:  nv = wdata_i & ~DW'(8'h20);
      IX_MODE: begin
        nv = regs_q[IX_MODE];
        nv[MODE2_BIT] = wdata_i[MODE2_BIT];
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (ireg_locked(i)) begin : g_lock
      assign regs_q[i] = DW'(ireg_reset(i));
    end else if (i == IX_ALT_STAT) begin : g_alt
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= DW'(ireg_reset(i));
        else begin
          if (wr_i && int'(iaddr_i) == i) q <= nv;
          if (stat_clr_i) q[6:4] <= 3'b000;
          if (pb_done_i) q[PB_IRQ_BIT] <= 1'b1;
        end
      end
      assign regs_q[i] = q;
    end else begin : g_std
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= DW'(ireg_reset(i));
        else if (wr_i && gate_ok && int'(iaddr_i) == i) q <= nv;
      end
      assign regs_q[i] = q;
    end
  end

  logic alt_fall;
  assign alt_fall = wr_i && int'(iaddr_i) == IX_ALT_STAT &&
                    regs_q[IX_ALT_STAT][PB_IRQ_BIT] && !wdata_i[PB_IRQ_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     int_q <= 1'b0;
    else if (pb_done_i)              int_q <= 1'b1;
    else if (stat_clr_i || alt_fall) int_q <= 1'b0;
  end

  assign regs_o = regs_q;
  assign int_o  = int_q;

  p_fmt_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && int'(iaddr_i) == IX_FMT && !mce_i && !regs_q[IX_ALT_STAT][PB_IRQ_BIT])
    |=> $stable(regs_q[IX_FMT]));
  p_fmt_low_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && int'(iaddr_i) == IX_FMT && !mce_i) |=> $stable(regs_q[IX_FMT][3:0]));
  p_mode_fixed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_q[IX_MODE] & ~DW'(8'h40)) == DW'(8'h8A));
  p_cfg_b5_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs_q[IX_CFG][5]);
  p_stat_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !pb_done_i) |=> !int_o && regs_q[IX_ALT_STAT][6:4] == 3'b000);
  p_alt_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_fall && !pb_done_i) |=> !int_o);
  p_pb_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_done_i |=> int_o && regs_q[IX_ALT_STAT][PB_IRQ_BIT]);
endmodule

// File: rtl/codec_regs.sv
module codec_regs #(
  parameter int NREG     = 32,
  parameter int CAL_LOAD = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  input  logic        pb_done_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic [7:0]  play_fmt_o,
  output logic        play_en_o,
  output logic        irq_en_o,
  output logic [15:0] play_count_o,
  output logic        mode2_o
);
  import codec_reg_pkg::*;

  localparam int DW = 8;
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(CAL_LOAD + 1);

  port_e port;
  assign port = port_e'(addr_i);

  logic [DW-1:0]           idx;
  logic [IW-1:0]           iaddr;
  logic                    mce, mce_rise, cal_busy, int_flag;
  logic [NREG-1:0][DW-1:0] regs;

  codec_index_port #(.DW(DW), .IW(IW)) u_index (
    .clk_i, .rst_ni,
    .wr_i      (wr_i && port == PORT_INDEX),
    .wdata_i,
    .mode2_i   (mode2_o),
    .idx_o     (idx),
    .iaddr_o   (iaddr),
    .mce_o     (mce),
    .mce_rise_o(mce_rise)
  );

  codec_cal_emu #(.CAL_LOAD(CAL_LOAD), .CW(CW)) u_cal (
    .clk_i, .rst_ni,
    .load_i (mce_rise && regs[IX_CFG][4:3] != 2'b00),
    .rd_i   (rd_i && port == PORT_DATA && int'(iaddr) == IX_INIT),
    .busy_o (cal_busy)
  );

  codec_ireg_file #(.DW(DW), .NREG(NREG), .IW(IW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i       (wr_i && port == PORT_DATA),
    .iaddr_i    (iaddr),
    .wdata_i,
    .mce_i      (mce),
    .stat_clr_i (wr_i && port == PORT_STATUS),
    .pb_done_i,
    .regs_o     (regs),
    .int_o      (int_flag)
  );

  always_comb begin
    case (port)
      PORT_INDEX:  rdata_o = idx;
      PORT_DATA: begin
        rdata_o = regs[iaddr];
        if (int'(iaddr) == IX_INIT && cal_busy) rdata_o[5] = 1'b1;
      end
      PORT_STATUS: rdata_o = {7'b0, int_flag};
      default:     rdata_o = '0;
    endcase
  end

  assign irq_o        = int_flag;
  assign mode2_o      = regs[IX_MODE][MODE2_BIT];
  assign play_fmt_o   = regs[IX_FMT];
  assign play_en_o    = regs[IX_CFG][0];
  assign irq_en_o     = regs[IX_PIN][1];
  assign play_count_o = {regs[IX_CNT_HI], regs[IX_CNT_LO]};

  p_idx_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port == PORT_INDEX |-> !rdata_o[7]);
  p_pio_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port == PORT_PIO |-> rdata_o == 8'h00);
endmodule

// File: tb/sim_codec_regs.sv
module sim_codec_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, pb_done = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, play_fmt;
  logic        irq, play_en, irq_en, mode2;
  logic [15:0] play_count;
  int checks = 0, errors = 0;
  logic [7:0] m [32];

  always #10 clk = ~clk;

  codec_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .pb_done_i(pb_done), .rdata_o(rdata), .irq_o(irq),
    .play_fmt_o(play_fmt), .play_en_o(play_en), .irq_en_o(irq_en),
    .play_count_o(play_count), .mode2_o(mode2)
  );

  function automatic logic [7:0] rv(input int i);
    if ((i >= 2 && i <= 5) || i == 18 || i == 19) return 8'h88;
    if (i == 6 || i == 7) return 8'h80;
    if (i == 9) return 8'h08;
    if (i == 12) return 8'h8A;
    if (i == 25 || i == 26) return 8'hA0;
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ireg_wr(input int i, input logic [7:0] d);
    bus_wr(2'd0, 8'h40 | 8'(i)); bus_wr(2'd1, d);
  endtask

  task automatic ireg_rd(input int i, output logic [7:0] d);
    bus_wr(2'd0, 8'h40 | 8'(i)); bus_rd(2'd1, d);
  endtask

  // model of a window write with index bit 6 set
  function automatic void model_wr(input int i, input logic [7:0] v);
    case (i)
      11, 22, 27, 29: ;
      9:  m[i] = v & 8'hDF;
      12: m[i] = (m[i] & 8'hBF) | (v & 8'h40);
      default: m[i] = v;
    endcase
  endfunction

  task automatic pulse_done();
    @(negedge clk); pb_done = 1'b1;
    @(negedge clk); pb_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset of direct ports
    bus_rd(2'd0, d); chk("R1 index reset", d, 8'h40);
    bus_rd(2'd2, d); chk("R1 status reset", d, 8'h00);
    bus_rd(2'd3, d); chk("R13 pio reset", d, 8'h00);
    chk("R1 irq reset", irq, 1'b0);

    // R2 bit 7 of index
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, d); chk("R2 index msb", d, 8'h7F);

    // R1 legacy sweep
    for (int i = 0; i < 16; i++) begin
      ireg_rd(i, d); chk($sformatf("R1 legacy reg %0d", i), d, rv(i));
    end
    // R3 legacy folds bit 4
    ireg_rd(25, d); chk("R3 legacy fold 25->9", d, 8'h08);
    ireg_rd(28, d); chk("R3 legacy fold 28->12", d, 8'h8A);

    // R4 mode register
    ireg_wr(12, 8'hFF); ireg_rd(12, d); chk("R4 mode set", d, 8'hCA);
    chk("R4 mode2_o", mode2, 1'b1);
    ireg_wr(12, 8'h3F); ireg_rd(12, d); chk("R4 mode clear", d, 8'h8A);
    chk("R4 mode2_o clear", mode2, 1'b0);
    ireg_wr(12, 8'h40);

    // R1 and R3 full sweep in extended mode
    for (int i = 0; i < 32; i++) begin
      m[i] = rv(i);
      ireg_rd(i, d);
      chk($sformatf("R1 R3 ext reg %0d", i), d, (i == 12) ? 8'hCA : rv(i));
    end
    m[12] = 8'hCA;

    // R5 R6 R12 write sweeps
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 32; i++) begin
        logic [7:0] v;
        v = 8'(i * 37 + k * 91 + 5);
        if (i == 12) v = v | 8'h40;
        ireg_wr(i, v); model_wr(i, v);
      end
      for (int i = 0; i < 32; i++) begin
        ireg_rd(i, d); chk($sformatf("R5 R6 sweep %0d reg %0d", k, i), d, m[i]);
      end
      chk("R12 play_fmt", play_fmt, m[8]);
      chk("R12 play_en", play_en, m[9][0]);
      chk("R12 irq_en", irq_en, m[10][1]);
      chk("R12 play_count", play_count, {m[14], m[15]});
    end

    // R7 format gate
    ireg_wr(9, 8'h00); ireg_wr(24, 8'h00); ireg_wr(8, 8'h3C);
    bus_wr(2'd0, 8'h08); bus_wr(2'd1, 8'h5A);
    ireg_rd(8, d); chk("R7 dropped", d, 8'h3C);
    ireg_wr(24, 8'h10);
    bus_wr(2'd0, 8'h08); bus_wr(2'd1, 8'hA7);
    ireg_rd(8, d); chk("R7 nibble merge", d, 8'hAC);
    chk("R12 play_fmt merged", play_fmt, 8'hAC);
    ireg_wr(8, 8'h51); ireg_rd(8, d); chk("R7 full with enable", d, 8'h51);
    ireg_wr(24, 8'h00);

    // R8 calibration emulation
    ireg_wr(9, 8'h08);
    bus_wr(2'd0, 8'h0B); bus_wr(2'd0, 8'h4B);
    bus_rd(2'd1, d); chk("R8 busy first read", d, 8'h20);
    bus_rd(2'd1, d); chk("R8 busy cleared", d, 8'h00);
    ireg_wr(9, 8'h10);
    bus_wr(2'd0, 8'h0B); bus_wr(2'd0, 8'h4B);
    bus_rd(2'd1, d); chk("R8 busy via bit4", d, 8'h20);
    ireg_wr(9, 8'h00);
    bus_wr(2'd0, 8'h0B); bus_wr(2'd0, 8'h4B);
    bus_rd(2'd1, d); chk("R8 no load when cfg zero", d, 8'h00);
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, d); chk("R5 read-only 11", d, 8'h00);

    // R11 R9 R10 interrupt
    pulse_done();
    chk("R11 irq set", irq, 1'b1);
    bus_rd(2'd2, d); chk("R11 status int", d, 8'h01);
    ireg_rd(24, d); chk("R11 alt bit4", d, 8'h10);
    ireg_wr(24, 8'h70);
    chk("R10 irq kept", irq, 1'b1);
    bus_wr(2'd2, 8'h00);
    chk("R9 irq cleared", irq, 1'b0);
    bus_rd(2'd2, d); chk("R9 status cleared", d, 8'h00);
    ireg_rd(24, d); chk("R9 alt cleared", d, 8'h00);
    pulse_done();
    ireg_wr(24, 8'h60);
    chk("R10 irq cleared", irq, 1'b0);
    ireg_rd(24, d); chk("R10 alt value", d, 8'h60);
    @(negedge clk); addr = 2'd2; wr = 1'b1; pb_done = 1'b1;
    @(negedge clk); wr = 1'b0; pb_done = 1'b0;
    chk("R11 set wins", irq, 1'b1);
    ireg_rd(24, d); chk("R11 alt set wins", d, 8'h10);

    // R13 PIO writes ignored
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd3, d); chk("R13 pio zero", d, 8'h00);
    bus_rd(2'd2, d); chk("R13 status untouched", d, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule